// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked single-port memory of 18-bit words, meant to serve as the data store of a cache. The address, the write data and every control strobe except the output enable are captured on the rising clock edge. The 18-bit data bus is bidirectional: the host drives write data onto it, and the block drives read data back onto the same wires.

A transfer begins when either of two start strobes is asserted. One start strobe is intended for a processor and the other for a cache controller. The address presented in that cycle is loaded. The following addresses of a four-beat line are produced by an internal 2-bit counter, which moves only when the advance strobe is asserted. Writes are timed by the clock edge alone and can update the low 9-bit lane, the high 9-bit lane, or both.

The full-size part has a 16-bit address. The `ADDR_W` parameter sets the depth and defaults to a smaller value, so that simulation stays light.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held and after it is released, the block is deselected and does not drive the data bus, even with the output enable low.
- R2: At a clock edge where the block is selected, `wrLoN` low stores bus bits 8:0 and `wrHiN` low stores bus bits 17:9 into the addressed word. A lane whose enable is high keeps its old contents.
- R3: `startProcN` low or `startCtrlN` low at an edge loads `addrIn` as the current address. The word at that address is on the bus after that same edge, provided the block is selected, `oeN` is low and no write took place at that edge.
- R4: With no start strobe and `advN` low, the current address increases by one in its two low bits only, wrapping from 3 back to 0 (for example 2, 3, 0, 1). The upper bits stay fixed. With `advN` high and no start strobe, the address holds.
- R5: When a start strobe and `advN` are both low at the same edge, the address is loaded from `addrIn` and is not advanced.
- R6: A start strobe with `ceN` high deselects the block. Once deselected, it does not drive the bus, ignores write enables and ignores `advN`, until a start strobe arrives with `ceN` low.
- R7: `oeN` acts without a clock: while it is high the bus is released at once, and when it returns low the read data reappears. After an edge that performed a write, the block does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture happens on its rising edge |
| rstN | input | 1 | Synchronous active-low reset of the selection and turnaround state |
| addrIn | input | ADDR_W | External word address, loaded on a start strobe |
| dq | inout | 18 | Shared write-data and read-data bus |
| startProcN | input | 1 | Processor-side transfer start, active low |
| startCtrlN | input | 1 | Controller-side transfer start, active low |
| advN | input | 1 | Burst advance, active low |
| ceN | input | 1 | Chip enable sampled at a start strobe, active low |
| wrLoN | input | 1 | Write enable for bus bits 8:0, active low |
| wrHiN | input | 1 | Write enable for bus bits 17:9, active low |
| oeN | input | 1 | Asynchronous output enable, active low |

## Verification
A four-beat line is written through the controller-side start strobe and then read back through the processor-side start strobe, beginning mid-line at offset 2. The read order 2, 3, 0, 1 separates a correct wrap of the low two bits from a carry into the upper bits. Writes to a single lane, with distinct patterns in each lane, show whether the enables are swapped or merged. A start strobe issued together with the advance strobe shows whether the load takes priority. A deselecting start followed by writes and advance pulses, then a reselected read, shows whether anything leaked while the block was idle. The output enable is toggled within a cycle, and the bus is sampled just after a write edge, to confirm the asynchronous gating and the turnaround behaviour.

// File: rtl/sram_pkg.sv
package sram_pkg;
  // Number of independently writable lanes on the data bus
  localparam int LANES = 2;

  // Per-edge strobes sent by the control to the datapath
  typedef struct packed {
    logic             loadAddr;  // take the external address
    logic             stepAddr;  // advance the low two address bits
    logic             capture;   // refresh the read register
    logic [LANES-1:0] laneWr;    // lane write strobes, bit 0 = low lane
  } sramStrobes_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startProcN,
  input  logic             startCtrlN,
  input  logic             advN,
  input  logic             ceN,
  input  logic [LANES-1:0] laneWrN,
  output sramStrobes_t     strobes,
  output logic             driveEn
);
  logic selQ;
  logic wrBusyQ;
  logic startAny;
  logic selNext;

  assign startAny = !startProcN || !startCtrlN;
  assign selNext  = startAny ? !ceN : selQ;

  always_comb begin
    strobes.loadAddr = startAny;
    strobes.stepAddr = !startAny && !advN && selQ;
    strobes.capture  = selNext;
    strobes.laneWr   = selNext ? ~laneWrN : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= 1'b0;
      wrBusyQ <= 1'b0;
    end else begin
      selQ    <= selNext;
      wrBusyQ <= |strobes.laneWr;
    end
  end

  assign driveEn = selQ && !wrBusyQ;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (startAny && ceN) |=> !driveEn); // R6
  AST_WRITE_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.laneWr) |=> !driveEn); // R7
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!selQ && !startAny) |-> (strobes.laneWr == '0)); // R6
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdQ
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] burstQ;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] effAddr;

  // Only the two low bits count; the line base stays put
  assign stepped = {burstQ[ADDR_W-1:2], burstQ[1:0] + 2'd1};

  always_comb begin
    if (strobes.loadAddr)      effAddr = addrIn;
    else if (strobes.stepAddr) effAddr = stepped;
    else                       effAddr = burstQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) burstQ <= '0;
    else       burstQ <= effAddr;
  end

  always_ff @(posedge clk) begin
    for (int ln = 0; ln < LANES; ln++) begin
      if (strobes.laneWr[ln])
        mem[effAddr][ln*LANE_W +: LANE_W] <= dqIn[ln*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) rdQ <= mem[effAddr];
  end

  AST_LOAD_EXTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> (burstQ == $past(addrIn))); // R5
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepAddr && !strobes.loadAddr) |=>
      (burstQ[1:0] == $past(burstQ[1:0]) + 2'd1) &&
      (burstQ[ADDR_W-1:2] == $past(burstQ[ADDR_W-1:2]))); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadAddr && !strobes.stepAddr) |=> $stable(burstQ)); // R4
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  inout  wire  [DATA_W-1:0] dq,
  input  logic              startProcN,
  input  logic              startCtrlN,
  input  logic              advN,
  input  logic              ceN,
  input  logic              wrLoN,
  input  logic              wrHiN,
  input  logic              oeN
);
  sramStrobes_t      strobes;
  logic              driveEn;
  logic              busOe;
  logic [DATA_W-1:0] rdQ;

  sram_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startProcN (startProcN),
    .startCtrlN (startCtrlN),
    .advN       (advN),
    .ceN        (ceN),
    .laneWrN    ({wrHiN, wrLoN}),
    .strobes    (strobes),
    .driveEn    (driveEn)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addrIn  (addrIn),
    .dqIn    (dq),
    .rdQ     (rdQ)
  );

  // Output enable is not registered: it gates the drivers directly
  assign busOe = driveEn && !oeN;
  assign dq    = busOe ? rdQ : 'z;

  AST_RESET_RELEASE: assert property (@(posedge clk)
    !rstN |=> !driveEn); // R1
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam logic [DW-1:0] FLOAT = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic sp = 1, sc = 1, adv = 1, ce = 1, wlo = 1, whi = 1, oe = 1;
  logic tbDrive = 0;
  logic [DW-1:0] tbData = '0;
  wire  [DW-1:0] dq;

  assign dq = tbDrive ? tbData : 'z;
  for (genvar i = 0; i < DW; i++) begin : g_pull
    pullup (dq[i]);
  end

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) u_sync_burst_sram (
    .clk(clk), .rstN(rstN), .addrIn(addr), .dq(dq),
    .startProcN(sp), .startCtrlN(sc), .advN(adv), .ceN(ce),
    .wrLoN(wlo), .wrHiN(whi), .oeN(oe)
  );

  int nVec = 0;
  int nBad = 0;

  typedef struct { logic [DW-1:0] val; string tag; } expItem_t;
  expItem_t scoreQ[$];

  logic [DW-1:0] model [int];
  logic [AW-1:0] mAddr = '0;
  bit mSel = 0;
  bit oeOn = 0;

  function automatic void check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %05h expected %05h at %0t", tag, act, exp, $time);
    end
  endfunction

  // Called just after a rising edge; returns 2 ns after the next one
  task automatic cycle(input bit spN, input bit scN, input bit advN_, input bit ceN_,
                       input bit wloN, input bit whiN, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input string tag);
    bit start;
    bit selNew;
    bit wr;
    logic [AW-1:0] eff;
    expItem_t it;
    start  = !spN || !scN;
    selNew = start ? !ceN_ : mSel;
    wr     = selNew && (!wloN || !whiN);
    sp = spN; sc = scN; adv = advN_; ce = ceN_; wlo = wloN; whi = whiN; addr = a;
    tbDrive = wr; tbData = wd;
    oe = (wr || !oeOn) ? 1'b1 : 1'b0;
    @(posedge clk);
    if (start)               eff = a;
    else if (mSel && !advN_) eff = {mAddr[AW-1:2], mAddr[1:0] + 2'd1};
    else                     eff = mAddr;
    if (selNew && !wr && oeOn) begin
      it.val = model.exists(int'(eff)) ? model[int'(eff)] : 'x;
      it.tag = tag;
      scoreQ.push_back(it);
    end
    if (selNew) begin
      if (!model.exists(int'(eff))) model[int'(eff)] = '0;
      if (!wloN) model[int'(eff)][8:0]  = wd[8:0];
      if (!whiN) model[int'(eff)][17:9] = wd[17:9];
    end
    mAddr = eff;
    mSel  = selNew;
    #2;
    tbDrive = 0;
  endtask

  task automatic checkFloat(input string tag);
    #1;
    check(tag, dq, FLOAT);
  endtask

  // Monitor: compares read data one nanosecond after each edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        check(it.tag, dq, it.val);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    oe = 0;
    checkFloat("R1 during reset");
    rstN = 1;
    @(posedge clk);
    #2;
    checkFloat("R1 after reset");

    // R2: write a line through the controller-side start, then advance
    cycle(1, 0, 1, 0, 0, 0, 10'h040, 18'h01111, "R2");
    cycle(1, 1, 0, 0, 0, 0, 10'h000, 18'h02222, "R2");
    cycle(1, 1, 0, 0, 0, 0, 10'h000, 18'h03333, "R2");
    cycle(1, 1, 0, 0, 0, 0, 10'h000, 18'h04444, "R2");

    // R3/R4: read from offset 2 through the processor-side start, wrap 2,3,0,1
    oeOn = 1;
    cycle(0, 1, 1, 0, 1, 1, 10'h042, '0, "R3 proc start");
    cycle(1, 1, 0, 0, 1, 1, 10'h000, '0, "R4 step to 3");
    cycle(1, 1, 0, 0, 1, 1, 10'h000, '0, "R4 wrap to 0");
    cycle(1, 1, 0, 0, 1, 1, 10'h000, '0, "R4 step to 1");
    cycle(1, 1, 1, 0, 1, 1, 10'h000, '0, "R4 hold");
    cycle(1, 0, 1, 0, 1, 1, 10'h040, '0, "R3 ctrl start");

    // R2: single-lane writes
    cycle(1, 0, 1, 0, 0, 0, 10'h081, 18'h2A0F5, "R2 both lanes");
    cycle(1, 1, 1, 0, 0, 1, 10'h000, 18'h00123, "R2 low lane");
    cycle(1, 1, 1, 0, 1, 1, 10'h000, '0, "R2 low lane read");
    cycle(1, 1, 1, 0, 1, 0, 10'h000, 18'h15400, "R2 high lane");
    cycle(1, 1, 1, 0, 1, 1, 10'h000, '0, "R2 high lane read");

    // R5: start and advance together load the external address
    cycle(0, 1, 0, 0, 1, 1, 10'h043, '0, "R5 start wins");
    cycle(1, 1, 0, 0, 1, 1, 10'h000, '0, "R5 then wrap");

    // R6: deselect, then writes and advance must be ignored
    cycle(1, 0, 1, 1, 0, 0, 10'h041, 18'h00000, "R6");
    checkFloat("R6 deselected");
    cycle(1, 1, 0, 0, 0, 0, 10'h000, 18'h00000, "R6");
    checkFloat("R6 still idle");
    cycle(0, 1, 1, 0, 1, 1, 10'h041, '0, "R6 contents kept");

    // R7: asynchronous output enable and write turnaround
    cycle(1, 1, 1, 0, 1, 1, 10'h000, '0, "R7 read");
    oe = 1;
    checkFloat("R7 oe high");
    oe = 0;
    #1;
    check("R7 oe low again", dq, 18'h02222);
    cycle(1, 1, 1, 0, 0, 0, 10'h000, 18'h05555, "R7");
    oe = 0;
    checkFloat("R7 after write");
    cycle(1, 1, 1, 0, 1, 1, 10'h000, '0, "R7 read after write");

    repeat (2) @(posedge clk);
    #2;
    if (scoreQ.size() != 0) begin
      nBad++;
      $display("FAIL R3: got %0d pending reads expected 0", scoreQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule